// File: doc/BRIEF.md
# Parallel Pseudo-Random Test Word Generator

This block feeds a serializing transmitter with test data: on every enabled clock it delivers one 8-bit word. A mode select chooses between four maximal-length pseudo-random sequences and a 40-bit pattern loaded by the user that repeats without end. The serializer sends bit 0 of each word first. For the pseudo-random modes, eight sequence steps are worked out together in one clock, so the word rate equals the clock rate.

The pseudo-random engine is a single Fibonacci shift register. Its feedback taps and its active length are set by the mode. The all-ones value is the seed. A guard watches the active part of the register, and if that part is ever all zero it loads the seed again, so the generator cannot lock up. Any change of mode restarts the chosen source: the register goes back to the seed and the pattern pointer goes back to word 0.

Top module: `prbs_pattern_gen`

## Requirements
- R1: While `rst_n` is low, `data_valid` is 0 and `data_out` is 0.
- R2: Mode code 0 produces the sequence b[n] = b[n-7] xor b[n-6] (x^7+x^6+1). The register starts at all ones. Each word carries eight consecutive bits with the earliest in bit 0. The stream repeats every 127 bits.
- R3: Mode codes 1, 2 and 3 produce the same kind of sequence with the tap pairs (15,14), (23,18) and (31,28). Each starts from the all-ones seed.
- R4: Mode codes 4 to 7 (mode bit 2 set) emit the stored 40-bit pattern as five words: bits 7:0 first, then 15:8, 23:16, 31:24 and 39:32. After the fifth word the output wraps back to bits 7:0.
- R5: In the clock where `mode` differs from the mode in force, `data_valid` is 0. After that clock the new source starts at its beginning: all-ones seed or pattern word 0.
- R6: A clock with `en` low gives `data_valid` 0 and does not advance the source. The next enabled word continues the stream with no word lost.
- R7: `pat_load` captures `pat_data` in every mode. In a pattern mode with `en` high, that same clock outputs `pat_data[7:0]` and the next word is `pat_data[15:8]`. A load with `en` low, or in a pseudo-random mode, sets the pattern pointer to word 0.
- R8: If the active register bits of a pseudo-random mode are all zero, that clock gives `data_valid` 0 and the register holds the all-ones seed after that clock.
- R9: Every output is registered. A word computed from the inputs at one rising edge appears at the ports right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Produce a word this clock |
| mode | input | 3 | 0..3 pseudo-random lengths 7/15/23/31, 4..7 user pattern |
| pat_data | input | 40 | User pattern |
| pat_load | input | 1 | Capture `pat_data` this clock |
| data_out | output | 8 | Test word, bit 0 sent first |
| data_valid | output | 1 | `data_out` was produced this clock |

## Verification
Two pairs of events can fall in one clock. A pattern load can arrive while the pattern stream is running, and it can also coincide with a mode change. The bench drives both cases. In the first, the word for that clock must be byte 0 of the new pattern and the stream must then go on from byte 1. In the second, there must be a gap clock, after which byte 0 of the newly loaded pattern appears. A second instance resets into the all-zero register state with enable already high, so the guard fires in the first clock. The bench checks that this clock gives no valid word and that the next clock starts the seed sequence.

// File: rtl/prbs_gen_pkg.sv
package prbs_gen_pkg;
  localparam int unsigned WORD_W   = 8;
  localparam int unsigned STATE_W  = 31;
  localparam int unsigned NUM_PRBS = 4;
  localparam int unsigned SEL_W    = $clog2(NUM_PRBS);

  // register length of sequence idx
  function automatic int unsigned prbs_len(input int unsigned idx);
    case (idx)
      0:       return 7;
      1:       return 15;
      2:       return 23;
      default: return 31;
    endcase
  endfunction

  // second feedback tap of sequence idx
  function automatic int unsigned prbs_tap(input int unsigned idx);
    case (idx)
      0:       return 6;
      1:       return 14;
      2:       return 18;
      default: return 28;
    endcase
  endfunction

  // bits covered by the active register length
  function automatic logic [STATE_W-1:0] prbs_mask(input int unsigned len);
    logic [STATE_W-1:0] m;
    m = '0;
    for (int i = 0; i < STATE_W; i++) begin
      if (i < len) m[i] = 1'b1;
    end
    return m;
  endfunction

  // two-bit mask selecting the feedback taps
  function automatic logic [STATE_W-1:0] prbs_taps(input int unsigned idx);
    logic [STATE_W-1:0] m;
    m = '0;
    for (int i = 0; i < STATE_W; i++) begin
      if (i == prbs_len(idx) - 1 || i == prbs_tap(idx) - 1) m[i] = 1'b1;
    end
    return m;
  endfunction

  // WORD_W sequence bits, earliest in bit 0
  function automatic logic [WORD_W-1:0] prbs_word(input logic [STATE_W-1:0] s,
                                                 input logic [STATE_W-1:0] taps);
    logic [STATE_W-1:0] st;
    logic [WORD_W-1:0]  w;
    logic               fb;
    st = s;
    w  = '0;
    for (int k = 0; k < WORD_W; k++) begin
      fb   = ^(st & taps);
      w[k] = fb;
      st   = {st[STATE_W-2:0], fb};
    end
    return w;
  endfunction

  // register state after WORD_W steps
  function automatic logic [STATE_W-1:0] prbs_next(input logic [STATE_W-1:0] s,
                                                  input logic [STATE_W-1:0] taps);
    logic [STATE_W-1:0] st;
    logic               fb;
    st = s;
    for (int k = 0; k < WORD_W; k++) begin
      fb = ^(st & taps);
      st = {st[STATE_W-2:0], fb};
    end
    return st;
  endfunction
endpackage

// File: rtl/prbs_lfsr_core.sv
module prbs_lfsr_core
  import prbs_gen_pkg::*;
#(
  parameter logic [STATE_W-1:0] RESET_SEED = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   sel,
  input  logic               advance,
  input  logic               reseed,
  output logic [WORD_W-1:0]  word_o,
  output logic               zero_o,
  output logic [STATE_W-1:0] state_o
);
  logic [STATE_W-1:0] state_q;
  logic [WORD_W-1:0]  cand_word [NUM_PRBS];
  logic [STATE_W-1:0] cand_next [NUM_PRBS];
  logic               cand_zero [NUM_PRBS];

  for (genvar g = 0; g < NUM_PRBS; g++) begin : g_seq
    localparam logic [STATE_W-1:0] TAPS = prbs_taps(g);
    localparam logic [STATE_W-1:0] MASK = prbs_mask(prbs_len(g));
    assign cand_word[g] = prbs_word(state_q, TAPS);
    assign cand_next[g] = prbs_next(state_q, TAPS);
    assign cand_zero[g] = ((state_q & MASK) == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       state_q <= RESET_SEED;
    else if (reseed)  state_q <= '1;
    else if (advance) state_q <= cand_next[sel];
  end

  assign word_o  = cand_word[sel];
  assign zero_o  = cand_zero[sel];
  assign state_o = state_q;
endmodule

// File: rtl/prbs_user_pattern.sv
module prbs_user_pattern
  import prbs_gen_pkg::*;
#(
  parameter int unsigned PAT_W = 40
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 load,
  input  logic [PAT_W-1:0]                     pat_in,
  input  logic                                 restart,
  input  logic                                 advance,
  output logic [WORD_W-1:0]                    word_o,
  output logic [$clog2(PAT_W/WORD_W)-1:0]      ptr_o
);
  localparam int unsigned PAT_WORDS = PAT_W / WORD_W;
  localparam int unsigned PTR_W     = $clog2(PAT_WORDS);
  localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(PAT_WORDS - 1);
  localparam logic [PTR_W-1:0] AFTER_LD  = PTR_W'(1 % PAT_WORDS);

  logic [PAT_W-1:0]  pat_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [PTR_W-1:0]  ptr_inc;
  logic [WORD_W-1:0] slot [PAT_WORDS];

  for (genvar g = 0; g < PAT_WORDS; g++) begin : g_slot
    assign slot[g] = pat_q[g*WORD_W +: WORD_W];
  end

  assign ptr_inc = (ptr_q == LAST_PTR) ? '0 : ptr_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)    pat_q <= '0;
    else if (load) pat_q <= pat_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        ptr_q <= '0;
    else if (restart)  ptr_q <= '0;
    else if (load)     ptr_q <= advance ? AFTER_LD : '0;
    else if (advance)  ptr_q <= ptr_inc;
  end

  assign word_o = load ? pat_in[WORD_W-1:0] : slot[ptr_q];
  assign ptr_o  = ptr_q;
endmodule

// File: rtl/prbs_pattern_gen.sv
module prbs_pattern_gen
  import prbs_gen_pkg::*;
#(
  parameter int unsigned        PAT_W      = 40,
  parameter logic [STATE_W-1:0] RESET_SEED = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [2:0]        mode,
  input  logic [PAT_W-1:0]  pat_data,
  input  logic              pat_load,
  output logic [WORD_W-1:0] data_out,
  output logic              data_valid
);
  localparam int unsigned PTR_W      = $clog2(PAT_W / WORD_W);
  localparam logic [2:0]  MODE_RESET = 3'd0;

  logic [2:0]         mode_q;
  logic               mode_chg;
  logic               user_sel;
  logic               lfsr_zero;
  logic               zero_det;
  logic               lfsr_adv;
  logic               pat_adv;
  logic [WORD_W-1:0]  lfsr_word;
  logic [WORD_W-1:0]  pat_word;
  logic [STATE_W-1:0] lfsr_state;
  logic [PTR_W-1:0]   pat_ptr;
  logic [WORD_W-1:0]  data_q;
  logic               valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_RESET;
    else        mode_q <= mode;
  end

  assign mode_chg = (mode != mode_q);
  assign user_sel = mode_q[2];
  assign zero_det = lfsr_zero && !user_sel;
  assign lfsr_adv = en && !user_sel && !mode_chg && !zero_det;
  assign pat_adv  = en && user_sel && !mode_chg;

  prbs_lfsr_core #(.RESET_SEED(RESET_SEED)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (mode_q[SEL_W-1:0]),
    .advance (lfsr_adv),
    .reseed  (mode_chg || zero_det),
    .word_o  (lfsr_word),
    .zero_o  (lfsr_zero),
    .state_o (lfsr_state)
  );

  prbs_user_pattern #(.PAT_W(PAT_W)) u_pat (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (pat_load),
    .pat_in  (pat_data),
    .restart (mode_chg),
    .advance (pat_adv),
    .word_o  (pat_word),
    .ptr_o   (pat_ptr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else if (mode_chg) begin
      valid_q <= 1'b0;
    end else if (en && user_sel) begin
      data_q  <= pat_word;
      valid_q <= 1'b1;
    end else if (en && !zero_det) begin
      data_q  <= lfsr_word;
      valid_q <= 1'b1;
    end else begin
      valid_q <= 1'b0;
    end
  end

  assign data_out   = data_q;
  assign data_valid = valid_q;
endmodule

// File: rtl/prbs_pattern_gen_chk.sv
module prbs_pattern_gen_chk
  import prbs_gen_pkg::*;
#(
  parameter int unsigned PAT_W = 40
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               en,
  input logic                               mode_chg,
  input logic                               zero_det,
  input logic                               user_sel,
  input logic                               pat_load,
  input logic [WORD_W-1:0]                  pat_byte0,
  input logic [WORD_W-1:0]                  data_out,
  input logic                               data_valid,
  input logic [$clog2(PAT_W/WORD_W)-1:0]    pat_ptr,
  input logic [STATE_W-1:0]                 lfsr_state
);
  localparam int unsigned PAT_WORDS = PAT_W / WORD_W;
  localparam int unsigned PTR_W     = $clog2(PAT_WORDS);

  p_idle_no_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !data_valid);

  p_modechg_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !data_valid);

  p_modechg_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (pat_ptr == '0 && lfsr_state == '1));

  p_zero_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    zero_det |=> (!data_valid && lfsr_state == '1));

  p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(pat_ptr) < PAT_WORDS);

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && user_sel && !mode_chg && !pat_load && pat_ptr == PTR_W'(PAT_WORDS - 1))
      |=> pat_ptr == '0);

  p_load_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_load && en && user_sel && !mode_chg)
      |=> (data_valid && data_out == $past(pat_byte0)));
endmodule

bind prbs_pattern_gen prbs_pattern_gen_chk #(.PAT_W(PAT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .mode_chg   (mode_chg),
  .zero_det   (zero_det),
  .user_sel   (user_sel),
  .pat_load   (pat_load),
  .pat_byte0  (pat_data[7:0]),
  .data_out   (data_out),
  .data_valid (data_valid),
  .pat_ptr    (pat_ptr),
  .lfsr_state (lfsr_state)
);

// File: tb/prbs_pattern_gen_bench.sv
module prbs_pattern_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P7_WORDS   = 127;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [39:0] pat_data = '0;
  logic        pat_load = 1'b0;
  logic [7:0]  data_out;
  logic        data_valid;
  logic        zs_en = 1'b0;
  logic [7:0]  zs_out;
  logic        zs_valid;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [30:0] m_hist;
  int          m_len;
  int          m_tap;
  logic        stream [0:P7_WORDS*8-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  prbs_pattern_gen u_prbs_pattern_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode),
    .pat_data(pat_data), .pat_load(pat_load),
    .data_out(data_out), .data_valid(data_valid)
  );

  prbs_pattern_gen #(.RESET_SEED('0)) u_prbs_pattern_gen_zs (
    .clk(clk), .rst_n(rst_n), .en(zs_en), .mode(3'd0),
    .pat_data(40'd0), .pat_load(1'b0),
    .data_out(zs_out), .data_valid(zs_valid)
  );

  task automatic check(input bit ok, input string req, input logic [39:0] act,
                       input logic [39:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // sequence model: newest bit kept in m_hist[0]
  task automatic model_start(input int len, input int tap);
    m_hist = '1;
    m_len  = len;
    m_tap  = tap;
  endtask

  function automatic logic [7:0] model_word();
    logic [7:0] w;
    logic nb;
    for (int k = 0; k < 8; k++) begin
      nb = m_hist[m_len-1] ^ m_hist[m_tap-1];
      m_hist = {m_hist[29:0], nb};
      w[k] = nb;
    end
    return w;
  endfunction

  function automatic logic [7:0] pat_byte(input logic [39:0] p, input int idx);
    return 8'((p >> (8 * (idx % 5))) & 40'hFF);
  endfunction

  task automatic run_prbs(input int words, input string req);
    logic [7:0] e;
    for (int i = 0; i < words; i++) begin
      tick();
      e = model_word();
      check(data_valid === 1'b1 && data_out === e, req, {31'd0, data_valid, data_out},
            {31'd1, e});
    end
  endtask

  task automatic change_mode(input logic [2:0] m, input string req);
    mode = m;
    tick();
    check(data_valid === 1'b0, req, 40'(data_valid), 40'd0);
  endtask

  initial begin
    logic [7:0] e;
    localparam logic [39:0] PAT_A = 40'hA1B2C3D4E5;
    localparam logic [39:0] PAT_B = 40'h13579BDF02;
    localparam logic [39:0] PAT_C = 40'hFEDCBA9876;
    localparam logic [39:0] PAT_D = 40'h55AA0FF0C3;

    // R1: reset state
    zs_en = 1'b1;
    repeat (3) tick();
    check(data_valid === 1'b0 && data_out === 8'd0, "R1", {31'd0, data_valid, data_out}, 40'd0);
    rst_n = 1'b1;

    // R8: all-zero start, guard fires with enable high
    tick();
    check(zs_valid === 1'b0, "R8 zero cycle", 40'(zs_valid), 40'd0);
    check(data_valid === 1'b0, "R6 main idle", 40'(data_valid), 40'd0);
    model_start(7, 6);
    for (int i = 0; i < 5; i++) begin
      tick();
      e = model_word();
      check(zs_valid === 1'b1 && zs_out === e, "R8 after reload", {31'd0, zs_valid, zs_out},
            {31'd1, e});
    end
    zs_en = 1'b0;

    // R2 and R9: 7-bit sequence, full period sweep
    model_start(7, 6);
    en = 1'b1;
    for (int i = 0; i < P7_WORDS; i++) begin
      tick();
      e = model_word();
      check(data_valid === 1'b1 && data_out === e, "R2 R9 prbs7", {31'd0, data_valid, data_out},
            {31'd1, e});
      for (int b = 0; b < 8; b++) stream[i*8+b] = data_out[b];
    end
    for (int n = 127; n < P7_WORDS*8; n += 7) begin
      check(stream[n] === stream[n-127], "R2 period", 40'(stream[n]), 40'(stream[n-127]));
    end

    // R3, R5, R6: 15-bit sequence with gap
    change_mode(3'd1, "R5 gap to 15");
    model_start(15, 14);
    run_prbs(300, "R3 prbs15");
    en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      check(data_valid === 1'b0, "R6 enable low", 40'(data_valid), 40'd0);
    end
    en = 1'b1;
    run_prbs(20, "R6 resume");

    change_mode(3'd2, "R5 gap to 23");
    model_start(23, 18);
    run_prbs(200, "R3 prbs23");
    change_mode(3'd3, "R5 gap to 31");
    model_start(31, 28);
    run_prbs(200, "R3 prbs31");

    // R7: load in a pseudo-random mode without enable
    en = 1'b0;
    pat_data = PAT_A;
    pat_load = 1'b1;
    tick();
    pat_load = 1'b0;
    check(data_valid === 1'b0, "R7 idle load", 40'(data_valid), 40'd0);

    // R4: pattern cycling and wrap
    en = 1'b1;
    change_mode(3'd4, "R5 gap to user");
    for (int i = 0; i < 12; i++) begin
      tick();
      e = pat_byte(PAT_A, i);
      check(data_valid === 1'b1 && data_out === e, "R4 pattern", {31'd0, data_valid, data_out},
            {31'd1, e});
    end

    // R7: load while streaming (pointer at 2)
    pat_data = PAT_B;
    pat_load = 1'b1;
    tick();
    pat_load = 1'b0;
    check(data_valid === 1'b1 && data_out === pat_byte(PAT_B, 0), "R7 bypass",
          {31'd0, data_valid, data_out}, {31'd1, pat_byte(PAT_B, 0)});
    for (int i = 1; i < 7; i++) begin
      tick();
      e = pat_byte(PAT_B, i);
      check(data_valid === 1'b1 && data_out === e, "R7 after load", {31'd0, data_valid, data_out},
            {31'd1, e});
    end

    // R7: load with enable low rewinds pointer
    en = 1'b0;
    pat_data = PAT_C;
    pat_load = 1'b1;
    tick();
    pat_load = 1'b0;
    check(data_valid === 1'b0, "R7 load no en", 40'(data_valid), 40'd0);
    en = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      e = pat_byte(PAT_C, i);
      check(data_valid === 1'b1 && data_out === e, "R7 rewind", {31'd0, data_valid, data_out},
            {31'd1, e});
    end

    // R5 with R7: mode change and load together, code 7 is a pattern mode
    pat_data = PAT_D;
    pat_load = 1'b1;
    mode = 3'd7;
    tick();
    pat_load = 1'b0;
    check(data_valid === 1'b0, "R5 collision gap", 40'(data_valid), 40'd0);
    for (int i = 0; i < 7; i++) begin
      tick();
      e = pat_byte(PAT_D, i);
      check(data_valid === 1'b1 && data_out === e, "R4 code7", {31'd0, data_valid, data_out},
            {31'd1, e});
    end

    // R5: back to 7-bit sequence restarts at seed
    change_mode(3'd0, "R5 gap to 7");
    model_start(7, 6);
    run_prbs(4, "R5 restart");

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule